// File: doc/BRIEF.md
# MII Receive Byte-Boundary Strobe Generator

This block watches the 4-bit nibble stream that an MII receive path delivers, one nibble per rising edge of the receive clock. It hunts for the start-of-frame delimiter: a 0xD nibble that follows a run of 0x5 preamble nibbles while receive data valid is high. Once the delimiter has been found, it marks the first nibble of every byte in the rest of the frame with a one-cycle strobe. An external consumer, such as an address filter or a header snooper, can then pair nibbles into bytes without keeping its own framing counter.

All of the logic runs on the receive clock alone and has no notion of absolute time, so it behaves the same at a 25 MHz or a 2.5 MHz nibble rate. The outputs are registered. Each output reports on the nibble that the most recent clock edge sampled, so the first strobe appears exactly one receive-clock cycle after the edge that caught the delimiter. When receive data valid drops, the frame ends and the block returns to hunting.

Top module: `mii_byte_strobe`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `byte_stb`, `frame_act` and `data_q` are 0. A reset in the middle of a frame abandons that frame, and detection starts again from zero preamble nibbles.
- R2: A delimiter is accepted when `rx_dv` is high, `rxd` is 0xD, and at least `PRE_MIN` (default 2) consecutive 0x5 nibbles with `rx_dv` high come directly before it. On the edge that samples the nibble after the delimiter, `byte_stb` and `frame_act` go high and `data_q` takes that nibble.
- R3: Counting the first data nibble as index 0, `byte_stb` is high for exactly one cycle after each edge that samples an even-indexed data nibble, and low after every other edge. The strobe comes every second cycle for the whole frame.
- R4: After each edge that samples a data nibble, `data_q` equals that nibble. At all other times `data_q` is 0.
- R5: `frame_act` is high after each edge that samples a data nibble of an accepted frame, and low after edges that sample preamble, the delimiter, or idle cycles.
- R6: The first edge that samples `rx_dv` low ends the frame: all outputs are 0 after that edge. The value of `rxd` while `rx_dv` is low is ignored. Nibble values 0x5 and 0xD inside a frame do not restart it or shift the strobe phase.
- R7: A 0xD nibble is not accepted if fewer than `PRE_MIN` consecutive 0x5 nibbles come before it. A nibble other than 0x5, or a cycle with `rx_dv` low, breaks the preamble run. After a rejected delimiter, the outputs stay 0 until a valid preamble and delimiter appear.
- R8: Preamble and delimiter nibbles never produce `byte_stb` or `frame_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; nibbles are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid from the MII |
| rxd | input | 4 | Receive nibble from the MII |
| byte_stb | output | 1 | One-cycle strobe marking the first nibble of each byte |
| frame_act | output | 1 | High while `data_q` carries a data nibble of the current frame |
| data_q | output | 4 | Registered copy of the sampled data nibble, aligned with `byte_stb` |

## Verification
Random frames with preambles of varied length and an odd or even number of data nibbles check that the strobe phase starts at the first data nibble and alternates correctly up to the frame end, whatever the byte parity of the last nibble. A frame whose payload repeats the preamble-and-delimiter pattern shows that in-frame nibble values cannot restart framing. Preambles that are too short, broken by a foreign nibble, or interrupted by a drop in data valid, and a delimiter with no preamble at all, separate a correct hunt from one that accepts any 0xD. A reset during an active frame confirms that all state is abandoned.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [0:0] {
    FR_HUNT = 1'b0,
    FR_DATA = 1'b1
  } fr_state_t;
endpackage

// File: rtl/mbs_sfd_detect.sv
module mbs_sfd_detect #(
  parameter int          NIB_W   = 4,
  parameter logic [3:0]  PRE_NIB = 4'h5,
  parameter logic [3:0]  SFD_NIB = 4'hD,
  parameter int          PRE_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hunting,
  input  logic             rx_dv,
  input  logic [NIB_W-1:0] rxd,
  output logic             sfd_hit
);
  localparam int CNT_W = (PRE_MIN > 0) ? $clog2(PRE_MIN + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PRE_MIN);

  logic [CNT_W-1:0] pre_run;
  logic             is_pre;
  logic             is_sfd;
  logic             run_ok;

  assign is_pre  = (rxd == NIB_W'(PRE_NIB));
  assign is_sfd  = (rxd == NIB_W'(SFD_NIB));
  assign run_ok  = (pre_run >= CNT_SAT);
  assign sfd_hit = hunting && rx_dv && is_sfd && run_ok;

  // Count consecutive preamble nibbles, saturating at the required minimum.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_run <= '0;
    end else if (!hunting || !rx_dv || !is_pre) begin
      pre_run <= '0;
    end else if (!run_ok) begin
      pre_run <= pre_run + 1'b1;
    end
  end
endmodule

// File: rtl/mbs_framer.sv
module mbs_framer
  import mbs_pkg::*;
#(
  parameter int NIBS_PER_BYTE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_dv,
  input  logic sfd_hit,
  output logic hunting,
  output logic nib_valid,
  output logic nib_first
);
  localparam int PH_W = (NIBS_PER_BYTE > 1) ? $clog2(NIBS_PER_BYTE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIBS_PER_BYTE - 1);

  fr_state_t       state;
  logic [PH_W-1:0] phase;

  assign hunting   = (state == FR_HUNT);
  assign nib_valid = (state == FR_DATA) && rx_dv;
  assign nib_first = nib_valid && (phase == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_HUNT;
    end else begin
      case (state)
        FR_HUNT: if (sfd_hit) state <= FR_DATA;
        FR_DATA: if (!rx_dv)  state <= FR_HUNT;
        default:              state <= FR_HUNT;
      endcase
    end
  end

  // Nibble position within the current byte; restarts at each delimiter.
  always_ff @(posedge clk) begin
    if (rst || sfd_hit) begin
      phase <= '0;
    end else if (nib_valid) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/mbs_out_stage.sv
module mbs_out_stage #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nib_valid,
  input  logic             nib_first,
  input  logic [NIB_W-1:0] rxd,
  output logic             byte_stb,
  output logic             frame_act,
  output logic [NIB_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_stb  <= 1'b0;
      frame_act <= 1'b0;
      data_q    <= '0;
    end else begin
      byte_stb  <= nib_first;
      frame_act <= nib_valid;
      data_q    <= nib_valid ? rxd : '0;
    end
  end
endmodule

// File: rtl/mii_byte_strobe.sv
module mii_byte_strobe #(
  parameter int         NIB_W         = 4,
  parameter logic [3:0] PRE_NIB       = 4'h5,
  parameter logic [3:0] SFD_NIB       = 4'hD,
  parameter int         PRE_MIN       = 2,
  parameter int         NIBS_PER_BYTE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_dv,
  input  logic [NIB_W-1:0] rxd,
  output logic             byte_stb,
  output logic             frame_act,
  output logic [NIB_W-1:0] data_q
);
  logic hunting;
  logic sfd_hit;
  logic nib_valid;
  logic nib_first;

  mbs_sfd_detect #(
    .NIB_W  (NIB_W),
    .PRE_NIB(PRE_NIB),
    .SFD_NIB(SFD_NIB),
    .PRE_MIN(PRE_MIN)
  ) u_sfd (
    .clk    (clk),
    .rst    (rst),
    .hunting(hunting),
    .rx_dv  (rx_dv),
    .rxd    (rxd),
    .sfd_hit(sfd_hit)
  );

  mbs_framer #(
    .NIBS_PER_BYTE(NIBS_PER_BYTE)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .rx_dv    (rx_dv),
    .sfd_hit  (sfd_hit),
    .hunting  (hunting),
    .nib_valid(nib_valid),
    .nib_first(nib_first)
  );

  mbs_out_stage #(
    .NIB_W(NIB_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .nib_valid(nib_valid),
    .nib_first(nib_first),
    .rxd      (rxd),
    .byte_stb (byte_stb),
    .frame_act(frame_act),
    .data_q   (data_q)
  );
endmodule

// File: rtl/mii_byte_strobe_chk.sv
module mii_byte_strobe_chk #(
  parameter int         NIB_W   = 4,
  parameter logic [3:0] SFD_NIB = 4'hD
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_dv,
  input logic [NIB_W-1:0] rxd,
  input logic             byte_stb,
  input logic             frame_act,
  input logic [NIB_W-1:0] data_q
);
  // R2: a frame opens with a strobe, directly after a delimiter nibble
  assert_open_stb_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_act) |-> byte_stb);
  assert_open_sfd_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_act) |-> ($past(rxd, 2) == NIB_W'(SFD_NIB)));

  // R3: strobe only inside a frame, one cycle wide, alternating
  assert_stb_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> frame_act);
  assert_stb_single_R3: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);
  assert_stb_alternate_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_act && !byte_stb) |=> (!frame_act || byte_stb));

  // R4: data copy follows the sampled nibble and is cleared outside frames
  assert_data_copy_R4: assert property (@(posedge clk) disable iff (rst)
    frame_act |-> (data_q == $past(rxd)));
  assert_data_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_act |-> (data_q == '0));

  // R6: data valid low closes the frame on the next edge
  assert_dv_low_ends_R6: assert property (@(posedge clk) disable iff (rst)
    !rx_dv |=> !frame_act);
endmodule

bind mii_byte_strobe mii_byte_strobe_chk #(
  .NIB_W  (NIB_W),
  .SFD_NIB(SFD_NIB)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_dv    (rx_dv),
  .rxd      (rxd),
  .byte_stb (byte_stb),
  .frame_act(frame_act),
  .data_q   (data_q)
);

// File: tb/mii_byte_strobe_tb.sv
module mii_byte_strobe_tb;
  localparam int PRE_MIN = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_dv = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       byte_stb;
  logic       frame_act;
  logic [3:0] data_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mii_byte_strobe #(.PRE_MIN(PRE_MIN)) u_dut (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rxd(rxd),
    .byte_stb(byte_stb), .frame_act(frame_act), .data_q(data_q)
  );

  function automatic logic exp_stb(input int idx);
    return (idx % 2) == 0;
  endfunction

  function automatic logic [3:0] nib_not5();
    logic [3:0] n;
    n = 4'($urandom);
    if (n == 4'h5) n = 4'h6;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Drive one nibble, then sample the outputs after the edge that caught it.
  task automatic step(input logic dv, input logic [3:0] nib, input logic e_act,
                      input logic e_stb, input logic [3:0] e_q, input string tag);
    rx_dv = dv;
    rxd   = nib;
    @(posedge clk);
    #2;
    chk({tag, " byte_stb R3"},  {3'b0, byte_stb},  {3'b0, e_stb});
    chk({tag, " frame_act R5"}, {3'b0, frame_act}, {3'b0, e_act});
    chk({tag, " data_q R4"},    data_q,            e_q);
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'($urandom), 1'b0, 1'b0, 4'h0, "R6 idle");
  endtask

  task automatic good_frame(input int pre_len, input int n_data, input bit tricky);
    logic [3:0] n;
    for (int i = 0; i < pre_len; i++) step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R8 preamble");
    step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R8 delimiter");
    for (int i = 0; i < n_data; i++) begin
      n = 4'($urandom);
      if (tricky && i < 6) n = (i == 3 || i == 5) ? 4'hD : 4'h5;
      step(1'b1, n, 1'b1, exp_stb(i), n, (i == 0) ? "R2 first" : "R6 data");
    end
    gap(1 + $urandom_range(0, 2));
  endtask

  // Nibbles after a rejected delimiter: no 0x5, so no hidden preamble forms.
  task automatic dead_data(input int n);
    for (int i = 0; i < n; i++) step(1'b1, nib_not5(), 1'b0, 1'b0, 4'h0, "R7 rejected");
  endtask

  task automatic reject_frame(input int kind);
    case (kind)
      0: begin  // too short
        step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R7 short");
        step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R7 short");
      end
      1: begin  // foreign nibble breaks the run
        step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R7 break");
        step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R7 break");
        step(1'b1, 4'h3, 1'b0, 1'b0, 4'h0, "R7 break");
        step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R7 break");
        step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R7 break");
      end
      2: begin  // data valid drop breaks the run
        step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R7 dvdrop");
        step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R7 dvdrop");
        step(1'b0, 4'h5, 1'b0, 1'b0, 4'h0, "R7 dvdrop");
        step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R7 dvdrop");
      end
      default: step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R7 bare");
    endcase
    dead_data(1 + $urandom_range(0, 8));
    gap(1 + $urandom_range(0, 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: a valid pattern during reset must not leak through
    step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R1 in reset");
    step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R1 in reset");
    step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R1 in reset");
    step(1'b1, 4'hA, 1'b0, 1'b0, 4'h0, "R1 in reset");
    rst = 1'b0;
    step(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R1 after reset");

    good_frame(PRE_MIN, 1, 1'b0);        // R2 minimum preamble, single nibble
    good_frame(PRE_MIN + 5, 7, 1'b0);    // R3 odd length
    good_frame(PRE_MIN + 1, 10, 1'b1);   // R6 in-frame preamble/delimiter values
    for (int k = 0; k < 4; k++) reject_frame(k);

    // R1: reset in the middle of a frame
    for (int i = 0; i < PRE_MIN; i++) step(1'b1, 4'h5, 1'b0, 1'b0, 4'h0, "R1 pre");
    step(1'b1, 4'hD, 1'b0, 1'b0, 4'h0, "R1 sfd");
    step(1'b1, 4'h9, 1'b1, 1'b1, 4'h9, "R1 data");
    step(1'b1, 4'h2, 1'b1, 1'b0, 4'h2, "R1 data");
    rst = 1'b1;
    step(1'b1, 4'h7, 1'b0, 1'b0, 4'h0, "R1 mid-frame reset");
    rst = 1'b0;
    dead_data(4);
    gap(2);

    for (int f = 0; f < 160; f++) begin
      if ((f % 7) == 3) reject_frame($urandom_range(0, 3));
      else good_frame(PRE_MIN + $urandom_range(0, 12), $urandom_range(1, 40), (f % 11) == 5);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule